// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where a small RISC core with 16-bit instruction words fetches next. Each cycle it takes the current word address, the instruction word just fetched, the eight-bit status byte, two register operands and a flag saying whether the instruction after the current one takes two words. From these it decides among sequential fetch, a PC-relative jump or call, a conditional branch on one status bit, and the skip-next-instruction tests. It also accepts a target that the core has worked out elsewhere, for absolute jumps, indirect jumps, returns and interrupt vectors, and passes it through.

The result is registered. Inputs presented before a rising clock edge appear on `next_pc_o` and `taken_o` after that edge. `taken_o` is high whenever the next address differs from the plain sequential one, because of a jump, a branch that was taken, a skip that was taken, or an external target. All address arithmetic wraps modulo 2^PC_W.

Top module: `pcu_next_pc`

## Requirements
- R1: While `rst_n` is low, and after it, until the first edge with reset released, `next_pc_o` is 0 and `taken_o` is 0.
- R2: For any word not decoded as a control word below, one edge later `next_pc_o` = `pc_i` + 1 and `taken_o` = 0.
- R3: A word with bits [15:13] = 110 (relative jump when bit 12 is 0, relative call when bit 12 is 1) always redirects: `next_pc_o` = `pc_i` + 1 + the signed 12-bit offset in bits [11:0], and `taken_o` = 1.
- R4: A word with bits [15:11] = 11110 is a conditional branch. Bits [2:0] select status bit 0..7 (carry, zero, negative, overflow, sign, half-carry, transfer, interrupt enable). Bit 10 = 0 branches when the selected bit is 1, and bit 10 = 1 branches when it is 0. A taken branch gives `pc_i` + 1 + the signed 7-bit offset in bits [9:3] with `taken_o` = 1. A branch that is not taken gives `pc_i` + 1 with `taken_o` = 0.
- R5: A word with bits [15:10] = 000100 is compare-and-skip. It skips when `opnd_a_i` equals `opnd_b_i` and otherwise gives `pc_i` + 1 with `taken_o` = 0.
- R6: A word with bits [15:10] = 11111x and bit 3 = 0 is a bit-test skip on `opnd_a_i` bit [2:0]. With bit 9 = 0 it skips when that bit is 0. With bit 9 = 1 it skips when that bit is 1. A word of this pattern with bit 3 = 1 is treated as sequential.
- R7: A taken skip gives `next_pc_o` = `pc_i` + 3 when `next_long_i` is 1 and `pc_i` + 2 when it is 0, with `taken_o` = 1.
- R8: All sums wrap modulo 2^PC_W, both forward past the top address and backward below zero.
- R9: When `ext_valid_i` is 1, `next_pc_o` = `ext_target_i` and `taken_o` = 1, whatever the instruction word, status and operands.
- R10: The offset extremes are honoured: -2048 and +2047 for relative jumps, -64 and +63 for branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | PC_W | Word address of the current instruction |
| instr_i | input | 16 | Instruction word fetched at `pc_i` |
| status_i | input | 8 | Status byte; bit n is the flag chosen by selector n |
| opnd_a_i | input | DATA_W | First compare operand and source for the bit test |
| opnd_b_i | input | DATA_W | Second compare operand |
| next_long_i | input | 1 | The instruction after the current one takes two words |
| ext_valid_i | input | 1 | Use `ext_target_i` as the next address |
| ext_target_i | input | PC_W | Externally computed target |
| next_pc_o | output | PC_W | Registered next fetch address |
| taken_o | output | 1 | Registered flag: next address is not the sequential one |

## Verification
Two decisions can meet in one cycle: an external target arrives while the instruction word is itself a control word whose condition holds, such as a skip with equal operands and a long following instruction, or a relative jump. The bench sets up exactly this clash and expects the external target to win with `taken_o` high. It also pairs the skip test with the long-instruction flag in both states, and expects the skip distance to follow the flag alone. Each case is judged against addresses the bench works out from the word fields and the wrap rule.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Instruction word width and fixed field widths of the encoding
    localparam int WORD_W = 16;
    localparam int REL_W  = 12;
    localparam int BR_W   = 7;
    localparam int SEL_W  = 3;

    typedef enum logic [2:0] {
        FLOW_SEQ      = 3'd0,
        FLOW_REL      = 3'd1,
        FLOW_BRANCH   = 3'd2,
        FLOW_SKIP_EQ  = 3'd3,
        FLOW_SKIP_BIT = 3'd4
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [REL_W-1:0]   rel_off;
        logic [BR_W-1:0]    br_off;
        logic [SEL_W-1:0]   sel;
        logic               want_clear;
    } dec_t;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o
);

    always_comb begin
        dec_o.kind       = FLOW_SEQ;
        dec_o.rel_off    = instr_i[REL_W-1:0];
        dec_o.br_off     = instr_i[9:3];
        dec_o.sel        = instr_i[SEL_W-1:0];
        dec_o.want_clear = instr_i[10];
        if (instr_i[15:13] == 3'b110) begin
            dec_o.kind = FLOW_REL;
        end else if (instr_i[15:11] == 5'b11110) begin
            dec_o.kind = FLOW_BRANCH;
        end else if (instr_i[15:10] == 6'b000100) begin
            dec_o.kind = FLOW_SKIP_EQ;
        end else if ((instr_i[15:10] == 6'b111110 || instr_i[15:10] == 6'b111111)
                     && !instr_i[3]) begin
            dec_o.kind       = FLOW_SKIP_BIT;
            dec_o.want_clear = ~instr_i[9];
        end
    end

endmodule

// File: rtl/pcu_cond.sv
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  dec_t              dec_i,
    input  logic [7:0]        status_i,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    output logic              take_o
);

    logic status_bit;
    logic opnd_bit;

    assign status_bit = status_i[dec_i.sel];
    assign opnd_bit   = opnd_a_i[dec_i.sel];

    always_comb begin
        unique case (dec_i.kind)
            FLOW_REL:      take_o = 1'b1;
            FLOW_BRANCH:   take_o = status_bit ^ dec_i.want_clear;
            FLOW_SKIP_EQ:  take_o = (opnd_a_i == opnd_b_i);
            FLOW_SKIP_BIT: take_o = opnd_bit ^ dec_i.want_clear;
            default:       take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_i,
    input  dec_t            dec_i,
    input  logic            take_i,
    input  logic            next_long_i,
    input  logic            ext_valid_i,
    input  logic [PC_W-1:0] ext_target_i,
    output logic [PC_W-1:0] npc_o,
    output logic            redirect_o
);

    localparam logic [PC_W-1:0] ONE      = PC_W'(1);
    localparam logic [PC_W-1:0] SKIP_SH  = PC_W'(2);
    localparam logic [PC_W-1:0] SKIP_LG  = PC_W'(3);

    logic [PC_W-1:0] rel_ext;
    logic [PC_W-1:0] br_ext;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] br_pc;
    logic [PC_W-1:0] skip_pc;

    // Sign extension, or truncation when the address is narrower than a field
    if (PC_W > REL_W) begin : g_rel_wide
        assign rel_ext = {{(PC_W-REL_W){dec_i.rel_off[REL_W-1]}}, dec_i.rel_off};
    end else begin : g_rel_narrow
        assign rel_ext = dec_i.rel_off[PC_W-1:0];
    end

    if (PC_W > BR_W) begin : g_br_wide
        assign br_ext = {{(PC_W-BR_W){dec_i.br_off[BR_W-1]}}, dec_i.br_off};
    end else begin : g_br_narrow
        assign br_ext = dec_i.br_off[PC_W-1:0];
    end

    // Independent adders run side by side; the mux picks one at the end
    assign seq_pc  = pc_i + ONE;
    assign rel_pc  = seq_pc + rel_ext;
    assign br_pc   = seq_pc + br_ext;
    assign skip_pc = pc_i + (next_long_i ? SKIP_LG : SKIP_SH);

    always_comb begin
        npc_o      = seq_pc;
        redirect_o = 1'b0;
        if (ext_valid_i) begin
            npc_o      = ext_target_i;
            redirect_o = 1'b1;
        end else if (take_i) begin
            redirect_o = 1'b1;
            unique case (dec_i.kind)
                FLOW_REL:      npc_o = rel_pc;
                FLOW_BRANCH:   npc_o = br_pc;
                FLOW_SKIP_EQ,
                FLOW_SKIP_BIT: npc_o = skip_pc;
                default: begin
                    npc_o      = seq_pc;
                    redirect_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [15:0]       instr_i,
    input  logic [7:0]        status_i,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic              next_long_i,
    input  logic              ext_valid_i,
    input  logic [PC_W-1:0]   ext_target_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    logic   take;
    logic [PC_W-1:0] npc;
    logic   redirect;

    pcu_decode i_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    pcu_cond #(.DATA_W(DATA_W)) i_cond (
        .dec_i    (dec),
        .status_i (status_i),
        .opnd_a_i (opnd_a_i),
        .opnd_b_i (opnd_b_i),
        .take_o   (take)
    );

    pcu_target #(.PC_W(PC_W)) i_target (
        .pc_i         (pc_i),
        .dec_i        (dec),
        .take_i       (take),
        .next_long_i  (next_long_i),
        .ext_valid_i  (ext_valid_i),
        .ext_target_i (ext_target_i),
        .npc_o        (npc),
        .redirect_o   (redirect)
    );

    always_comb begin
        st_d.pc    = npc;
        st_d.taken = redirect;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc_o = st_q.pc;
    assign taken_o   = st_q.taken;

    // Marks that the previous edge already ran with reset released
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2
    seq_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !taken_o |-> next_pc_o == PC_W'($past(pc_i) + PC_W'(1)));

    // R9
    ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(ext_valid_i) |-> taken_o && next_pc_o == $past(ext_target_i));

    // R3
    rel_always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(instr_i[15:13] == 3'b110) |-> taken_o);

    // R7
    skip_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!ext_valid_i && take &&
                           (dec.kind == FLOW_SKIP_EQ || dec.kind == FLOW_SKIP_BIT))
        |-> next_pc_o == PC_W'($past(pc_i) + ($past(next_long_i) ? PC_W'(3) : PC_W'(2))));

    // R5
    skip_eq_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!ext_valid_i && instr_i[15:10] == 6'b000100 &&
                           opnd_a_i != opnd_b_i) |-> !taken_o);

endmodule

// File: tb/test_pcu_next_pc.sv
module test_pcu_next_pc;

    localparam int PW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pc = '0;
    logic [15:0]   instr = '0;
    logic [7:0]    status = '0;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb = '0;
    logic          lng = 1'b0;
    logic          extv = 1'b0;
    logic [PW-1:0] extt = '0;
    logic [PW-1:0] next_pc;
    logic          taken;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcu_next_pc #(.PC_W(PW), .DATA_W(DW)) i_pcu_next_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_i         (pc),
        .instr_i      (instr),
        .status_i     (status),
        .opnd_a_i     (opa),
        .opnd_b_i     (opb),
        .next_long_i  (lng),
        .ext_valid_i  (extv),
        .ext_target_i (extt),
        .next_pc_o    (next_pc),
        .taken_o      (taken)
    );

    function automatic logic [15:0] br_word(input bit clr, input int off, input int sel);
        logic [6:0] o = off[6:0];
        return {5'b11110, clr, o, sel[2:0]};
    endfunction

    function automatic logic [15:0] rel_word(input bit call, input int off);
        logic [11:0] o = off[11:0];
        return {3'b110, call, o};
    endfunction

    task automatic drv(input logic [PW-1:0] p, input logic [15:0] w,
                       input logic [7:0] s, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic l);
        pc = p; instr = w; status = s; opa = a; opb = b; lng = l;
        extv = 1'b0; extt = '0;
    endtask

    task automatic check_now(input string tag, input logic [PW-1:0] exp_pc, input logic exp_tk);
        total++;
        if (next_pc !== exp_pc || taken !== exp_tk) begin
            bad++;
            $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b",
                     tag, next_pc, taken, exp_pc, exp_tk);
        end
    endtask

    task automatic step_check(input string tag, input logic [PW-1:0] exp_pc, input logic exp_tk);
        @(posedge clk);
        @(negedge clk);
        check_now(tag, exp_pc, exp_tk);
    endtask

    task automatic t_reset;
        drv(16'h1234, rel_word(0, 5), 8'hFF, 8'h1, 8'h1, 1'b1);
        extv = 1'b1; extt = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1 reset", 16'h0000, 1'b0);
        rst_n = 1'b1;
        extv = 1'b0;
    endtask

    task automatic t_sequential;
        drv(16'h0100, 16'h0000, 8'hFF, 8'h3, 8'h3, 1'b1);
        step_check("R2 no-op word", 16'h0101, 1'b0);
        drv(16'h0200, 16'h2C01, 8'hFF, 8'h0, 8'h0, 1'b0);
        step_check("R2 move word", 16'h0201, 1'b0);
        drv(16'h0300, 16'h940C, 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R2 long-form word", 16'h0301, 1'b0);
    endtask

    task automatic t_relative;
        drv(16'h0100, rel_word(0, 5), 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R3 jump +5", 16'h0106, 1'b1);
        drv(16'h0400, rel_word(1, -16), 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R3 call -16", 16'h03F1, 1'b1);
        drv(16'h1000, rel_word(1, -2048), 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R10 rel -2048", 16'h0801, 1'b1);
        drv(16'h0000, rel_word(0, 2047), 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R10 rel +2047", 16'h0800, 1'b1);
    endtask

    task automatic t_branch;
        for (int s = 0; s < 8; s++) begin
            logic [7:0] one_hot = 8'(1 << s);
            drv(16'h0500, br_word(0, 3, s), one_hot, 8'h0, 8'h0, 1'b0);
            step_check($sformatf("R4 set-branch sel %0d taken", s), 16'h0504, 1'b1);
            drv(16'h0500, br_word(1, 3, s), one_hot, 8'h0, 8'h0, 1'b0);
            step_check($sformatf("R4 clear-branch sel %0d not taken", s), 16'h0501, 1'b0);
            drv(16'h0500, br_word(1, -3, s), ~one_hot, 8'h0, 8'h0, 1'b0);
            step_check($sformatf("R4 clear-branch sel %0d taken", s), 16'h04FE, 1'b1);
            drv(16'h0500, br_word(0, -3, s), ~one_hot, 8'h0, 8'h0, 1'b0);
            step_check($sformatf("R4 set-branch sel %0d not taken", s), 16'h0501, 1'b0);
        end
        drv(16'h0800, br_word(0, -64, 1), 8'h02, 8'h0, 8'h0, 1'b0);
        step_check("R10 branch -64", 16'h07C1, 1'b1);
        drv(16'h0800, br_word(0, 63, 1), 8'h02, 8'h0, 8'h0, 1'b0);
        step_check("R10 branch +63", 16'h0840, 1'b1);
    endtask

    task automatic t_skip_eq;
        drv(16'h0600, 16'h1012, 8'h00, 8'h5A, 8'h5A, 1'b0);
        step_check("R5 R7 equal short", 16'h0602, 1'b1);
        drv(16'h0600, 16'h1012, 8'h00, 8'h5A, 8'h5A, 1'b1);
        step_check("R5 R7 equal long", 16'h0603, 1'b1);
        drv(16'h0600, 16'h1012, 8'hFF, 8'h5A, 8'h5B, 1'b1);
        step_check("R5 unequal", 16'h0601, 1'b0);
    endtask

    task automatic t_skip_bit;
        drv(16'h0700, 16'hFE04, 8'h00, 8'h10, 8'h00, 1'b0);
        step_check("R6 skip-if-set bit4 set", 16'h0702, 1'b1);
        drv(16'h0700, 16'hFC04, 8'h00, 8'h10, 8'h00, 1'b0);
        step_check("R6 skip-if-clear bit4 set", 16'h0701, 1'b0);
        drv(16'h0700, 16'hFC07, 8'h00, 8'h7F, 8'h00, 1'b1);
        step_check("R6 R7 skip-if-clear bit7 clear long", 16'h0703, 1'b1);
        drv(16'h0700, 16'hFE00, 8'h00, 8'hFE, 8'h00, 1'b0);
        step_check("R6 skip-if-set bit0 clear", 16'h0701, 1'b0);
        drv(16'h0700, 16'hFE0C, 8'h00, 8'hFF, 8'h00, 1'b0);
        step_check("R6 bit3 set is sequential", 16'h0701, 1'b0);
    endtask

    task automatic t_wrap;
        drv(16'hFFFF, 16'h0000, 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R8 sequential wrap", 16'h0000, 1'b0);
        drv(16'h0000, rel_word(0, -2), 8'h00, 8'h0, 8'h0, 1'b0);
        step_check("R8 backward wrap", 16'hFFFF, 1'b1);
        drv(16'hFFFE, 16'h1000, 8'h00, 8'h0, 8'h0, 1'b1);
        step_check("R8 skip wrap", 16'h0001, 1'b1);
    endtask

    task automatic t_external;
        drv(16'h0100, rel_word(0, 5), 8'h00, 8'h0, 8'h0, 1'b0);
        extv = 1'b1; extt = 16'h2A00;
        step_check("R9 external over jump", 16'h2A00, 1'b1);
        drv(16'h0600, 16'h1012, 8'h00, 8'h33, 8'h33, 1'b1);
        extv = 1'b1; extt = 16'h0042;
        step_check("R9 external over skip", 16'h0042, 1'b1);
        drv(16'h0900, 16'h0000, 8'h00, 8'h0, 8'h0, 1'b0);
        extv = 1'b1; extt = 16'h0901;
        step_check("R9 external equal to sequential", 16'h0901, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_sequential();
        t_relative();
        t_branch();
        t_skip_eq();
        t_skip_bit();
        t_wrap();
        t_external();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule